// File: doc/BRIEF.md
# Multi-Channel DMA Register Front-End

This block is the software-facing register layer of a sixteen-channel DMA controller. It takes single-cycle 32-bit word accesses and turns them into accesses to one of the per-channel register windows or to one of two global vectors. For each channel it holds the control/status word, the control-block pointer and a debug word. It also keeps read-only copies of the six control-block fields that the channel engine reports after it loads a block.

The front-end handles the side effects of status writes. These are a self-clearing channel reset, write-one-to-clear flags for completion and interrupt, and a masked merge of the writable status bits. When a write moves a channel from idle to active, the block sends a one-cycle start pulse to that channel's engine. When the engine reports completion, the block updates the channel's flags and drives that channel's interrupt line. The last channel has its own decode window, selected by a dedicated input, and uses the same per-channel layout.

Top module: `dma_regfront`

## Requirements
- R1: With `req_hi` low and `req_addr` below 0xF00, `req_addr[11:8]` picks the channel and `req_addr[7:0]` picks the register. With `req_hi` high, channel 15 is addressed and `req_addr[7:0]` picks the register. Read data appears on `rd_data` in the cycle after the read request.
- R2: Per-channel register offsets: 0x00 status, 0x04 control-block pointer (read/write), 0x20 debug word (read/write), and 0x08 + 4*k read-only copies of block field k (k = 0..5). A field copy is loaded from `ld_data` when `ld_valid` is high and `ld_idx` = k. Writes to the copies are ignored.
- R3: Offset 0xFE0 reads the 16-bit interrupt status vector, and writes to it are ignored. Offset 0xFF0 is the 16-bit channel enable vector, driven on `chan_en`.
- R4: Writing a status word with bit 31 set first clears that channel's status word and control-block pointer. The masked merge of R7 is then applied. The debug word and field copies are kept.
- R5: Writing a status word with bit 1 (end flag) set clears that flag.
- R6: Writing a status word with bit 2 (interrupt flag) set clears that flag, clears the channel's bit in the interrupt status vector, and drops `irq` for that channel in the next cycle.
- R7: On a status write, the bits under mask 0x30FF0001 take the written value, and all other status bits keep their value. Bit 30 has no effect.
- R8: A status write that moves bit 0 (active) from 0 to 1 on a channel whose enable bit is 1 makes `start` for that channel high for exactly one cycle, the cycle after the write. No other event raises `start`.
- R9: `done_valid` for channel `done_chan` sets status bit 1, sets status bit 4 (paused), and clears bit 0. If `done_int` is also high, it sets status bit 2 and the channel's bit in the status vector, and `irq` for that channel rises in the next cycle.
- R10: When a completion with `done_int` and a status write that clears bit 2 hit the same channel in the same cycle, the completion wins: the flag, the status vector bit and `irq` end up set.
- R11: Offsets that are not listed, including misaligned ones and window offsets of 0xF00 and above other than 0xFE0 and 0xFF0, read as zero and ignore writes.
- R12: After reset, all status words, pointers, debug words, field copies and the status vector are zero, the enable vector is 0xFFFF, and `irq`, `start` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi | input | 1 | Selects the separate channel-15 window |
| req_addr | input | 12 | Byte address within the selected window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ld_valid | input | 1 | Engine reports a loaded block field |
| ld_chan | input | 4 | Channel of the loaded field |
| ld_idx | input | 3 | Field index 0..5 |
| ld_data | input | 32 | Field value |
| done_valid | input | 1 | Engine reports block completion |
| done_chan | input | 4 | Channel that completed |
| done_int | input | 1 | Completion requests an interrupt |
| chan_en | output | 16 | Channel enable vector |
| start | output | 16 | One-cycle start pulse per channel |
| irq | output | 16 | Interrupt line per channel |

## Verification
Two functions can fall in the same cycle: a software write that clears a channel's interrupt flag, and an engine completion that sets the same flag. The bench first puts a channel's interrupt flag up. It then drives the status write with bit 2 and a completion with the interrupt request for that channel on the same clock edge. The outcome counts as correct only if the status word, the status vector bit and the interrupt line all remain set. A separate later write then clears all three.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int NCH   = 16;
    localparam int CW    = $clog2(NCH);
    localparam int NMIR  = 6;
    localparam int MW    = $clog2(NMIR);

    localparam logic [DW-1:0] CS_WMASK = 32'h30FF_0001;
    localparam int CS_ACT   = 0;
    localparam int CS_END   = 1;
    localparam int CS_INT   = 2;
    localparam int CS_PAUSE = 4;
    localparam int CS_RST   = 31;

    localparam logic [AW-1:0] GLOB_BASE = 12'hF00;
    localparam logic [AW-1:0] GSTAT_OFF = 12'hFE0;
    localparam logic [AW-1:0] GEN_OFF   = 12'hFF0;

    typedef enum logic [2:0] {
        T_NONE, T_CS, T_CBA, T_MIR, T_DBG, T_GSTAT, T_GEN
    } tgt_e;

    typedef struct packed {
        tgt_e          tgt;
        logic [CW-1:0] chan;
        logic [MW-1:0] midx;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a, input logic hi);
        dec_t       d;
        logic [7:0] off;
        logic [7:0] rel;
        off    = a[7:0];
        rel    = off - 8'h08;
        d.tgt  = T_NONE;
        d.chan = hi ? CW'(NCH - 1) : a[11:8];
        d.midx = '0;
        if (hi || a < GLOB_BASE) begin
            case (off)
                8'h00: d.tgt = T_CS;
                8'h04: d.tgt = T_CBA;
                8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C: begin
                    d.tgt  = T_MIR;
                    d.midx = MW'(rel >> 2);
                end
                8'h20: d.tgt = T_DBG;
                default: d.tgt = T_NONE;
            endcase
        end else if (a == GSTAT_OFF) begin
            d.tgt = T_GSTAT;
        end else if (a == GEN_OFF) begin
            d.tgt = T_GEN;
        end
        return d;
    endfunction

endpackage

// File: rtl/dmafe_chan.sv
module dmafe_chan
    import dmafe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     wr_cs,
    input  logic                     wr_cba,
    input  logic                     wr_dbg,
    input  logic [DW-1:0]            wdata,
    input  logic                     ld_v,
    input  logic [MW-1:0]            ld_idx,
    input  logic [DW-1:0]            ld_data,
    input  logic                     dn_v,
    input  logic                     dn_int,
    output logic [DW-1:0]            cs,
    output logic [DW-1:0]            cba,
    output logic [DW-1:0]            dbg,
    output logic [NMIR-1:0][DW-1:0]  mir,
    output logic                     start,
    output logic                     int_set,
    output logic                     int_clr
);

    logic [DW-1:0] cs_w;
    logic [DW-1:0] cs_n;
    logic          go;

    // software side effects first, engine completion applied on top
    always_comb begin
        cs_w = cs;
        if (wr_cs) begin
            if (wdata[CS_RST]) cs_w = '0;
            if (wdata[CS_END]) cs_w[CS_END] = 1'b0;
            if (wdata[CS_INT]) cs_w[CS_INT] = 1'b0;
            cs_w = (cs_w & ~CS_WMASK) | (wdata & CS_WMASK);
        end
        cs_n = cs_w;
        if (dn_v) begin
            cs_n[CS_END]   = 1'b1;
            cs_n[CS_ACT]   = 1'b0;
            cs_n[CS_PAUSE] = 1'b1;
            if (dn_int) cs_n[CS_INT] = 1'b1;
        end
    end

    assign go      = wr_cs && !cs[CS_ACT] && cs_w[CS_ACT] && en;
    assign int_set = dn_v && dn_int;
    assign int_clr = wr_cs && wdata[CS_INT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs    <= '0;
            cba   <= '0;
            dbg   <= '0;
            start <= 1'b0;
        end else begin
            cs    <= cs_n;
            start <= go;
            if (wr_cs && wdata[CS_RST]) cba <= '0;
            else if (wr_cba)            cba <= wdata;
            if (wr_dbg) dbg <= wdata;
        end
    end

    for (genvar k = 0; k < NMIR; k++) begin : g_mir
        always_ff @(posedge clk) begin
            if (rst)                                mir[k] <= '0;
            else if (ld_v && ld_idx == MW'(k))      mir[k] <= ld_data;
        end
    end

endmodule

// File: rtl/dmafe_glob.sv
module dmafe_glob
    import dmafe_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] set,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] enable,
    output logic [NCH-1:0] gstat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '1;
            gstat  <= '0;
        end else begin
            if (wr_en) enable <= wdata;
            gstat <= (gstat & ~clr) | set;
        end
    end

endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
    import dmafe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_hi,
    input  logic [11:0]   req_addr,
    input  logic [31:0]   req_wdata,
    output logic [31:0]   rd_data,
    input  logic          ld_valid,
    input  logic [3:0]    ld_chan,
    input  logic [2:0]    ld_idx,
    input  logic [31:0]   ld_data,
    input  logic          done_valid,
    input  logic [3:0]    done_chan,
    input  logic          done_int,
    output logic [15:0]   chan_en,
    output logic [15:0]   start,
    output logic [15:0]   irq
);

    dec_t                          dec;
    logic                          wr;
    logic                          rd;
    logic [NCH-1:0][DW-1:0]        cs_a;
    logic [NCH-1:0][DW-1:0]        cba_a;
    logic [NCH-1:0][DW-1:0]        dbg_a;
    logic [NCH-1:0][NMIR-1:0][DW-1:0] mir_a;
    logic [NCH-1:0]                iset;
    logic [NCH-1:0]                iclr;
    logic [NCH-1:0]                gstat;
    logic [DW-1:0]                 rd_n;

    assign dec = decode(req_addr, req_hi);
    assign wr  = req_valid && req_write;
    assign rd  = req_valid && !req_write;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (dec.chan == CW'(c));
        dmafe_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .en      (chan_en[c]),
            .wr_cs   (wr && sel && dec.tgt == T_CS),
            .wr_cba  (wr && sel && dec.tgt == T_CBA),
            .wr_dbg  (wr && sel && dec.tgt == T_DBG),
            .wdata   (req_wdata),
            .ld_v    (ld_valid && ld_chan == CW'(c)),
            .ld_idx  (ld_idx),
            .ld_data (ld_data),
            .dn_v    (done_valid && done_chan == CW'(c)),
            .dn_int  (done_int),
            .cs      (cs_a[c]),
            .cba     (cba_a[c]),
            .dbg     (dbg_a[c]),
            .mir     (mir_a[c]),
            .start   (start[c]),
            .int_set (iset[c]),
            .int_clr (iclr[c])
        );
    end

    dmafe_glob u_glob (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr && dec.tgt == T_GEN),
        .wdata  (req_wdata[NCH-1:0]),
        .set    (iset),
        .clr    (iclr),
        .enable (chan_en),
        .gstat  (gstat)
    );

    assign irq = gstat;

    always_comb begin
        case (dec.tgt)
            T_CS:    rd_n = cs_a[dec.chan];
            T_CBA:   rd_n = cba_a[dec.chan];
            T_DBG:   rd_n = dbg_a[dec.chan];
            T_MIR:   rd_n = mir_a[dec.chan][dec.midx];
            T_GSTAT: rd_n = DW'(gstat);
            T_GEN:   rd_n = DW'(chan_en);
            default: rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_data <= '0;
        else if (rd) rd_data <= rd_n;
    end

endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_hi,
    input logic [11:0] req_addr,
    input logic [31:0] rd_data,
    input logic        done_valid,
    input logic        done_int,
    input logic [15:0] chan_en,
    input logic [15:0] start,
    input logic [15:0] irq
);

    // R8
    start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start));

    // R8
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|start) |-> $past(req_valid && req_write));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(irq & ~$past(irq))) |-> $past(done_valid && done_int));

    // R3
    gstat_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_hi && req_addr == 12'hFE0 && !done_valid)
        |=> (irq == $past(irq)));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_hi && req_addr == 12'hF04)
        |=> (rd_data == 32'h0));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (chan_en == 16'hFFFF && irq == 16'h0 && start == 16'h0));

endmodule

bind dma_regfront dma_regfront_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_hi     (req_hi),
    .req_addr   (req_addr),
    .rd_data    (rd_data),
    .done_valid (done_valid),
    .done_int   (done_int),
    .chan_en    (chan_en),
    .start      (start),
    .irq        (irq)
);

// File: tb/sim_dma_regfront.sv
module sim_dma_regfront;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_hi = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_chan = '0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_chan = '0;
    logic        done_int = 1'b0;
    logic [15:0] chan_en;
    logic [15:0] start;
    logic [15:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] last_start;

    always #2 clk = ~clk;

    dma_regfront u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic hi, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_hi = hi; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_hi = 1'b0;
        last_start = start;
    endtask

    task automatic rd(input logic hi, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_hi = hi; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_hi = 1'b0;
        d = rd_data;
    endtask

    task automatic done(input logic [3:0] c, input logic it);
        @(negedge clk);
        done_valid = 1'b1; done_chan = c; done_int = it;
        @(negedge clk);
        done_valid = 1'b0; done_int = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 12'h000, v); chk("R12 cs0", v, 0);
        rd(0, 12'h704, v); chk("R12 cba7", v, 0);
        rd(0, 12'hFF0, v); chk("R12 enable", v, 32'hFFFF);
        rd(0, 12'hFE0, v); chk("R12 gstat", v, 0);
        chk("R12 irq", {16'h0, irq}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(0, 12'h304, 32'h1234_5670);
        wr(0, 12'h520, 32'hCAFE_0005);
        rd(0, 12'h304, v); chk("R1 R2 cba ch3", v, 32'h1234_5670);
        rd(0, 12'h520, v); chk("R2 dbg ch5", v, 32'hCAFE_0005);
        rd(0, 12'h504, v); chk("R1 cba ch5 separate", v, 0);
        wr(1, 12'h004, 32'hABCD_0000);
        rd(1, 12'h004, v); chk("R1 ch15 window cba", v, 32'hABCD_0000);
        rd(0, 12'h004, v); chk("R1 ch0 unaffected by ch15", v, 0);
    endtask

    task automatic t_mirror();
        logic [31:0] v;
        @(negedge clk);
        ld_valid = 1'b1; ld_chan = 4'd2; ld_idx = 3'd3; ld_data = 32'hDEAD_0003;
        @(negedge clk);
        ld_valid = 1'b0;
        rd(0, 12'h214, v); chk("R2 mirror field3", v, 32'hDEAD_0003);
        wr(0, 12'h214, 32'h0);
        rd(0, 12'h214, v); chk("R2 mirror write ignored", v, 32'hDEAD_0003);
        rd(0, 12'h208, v); chk("R2 mirror field0", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(0, 12'hF04, v); chk("R11 global hole", v, 0);
        rd(0, 12'h306, v); chk("R11 misaligned read", v, 0);
        wr(0, 12'h306, 32'hFFFF_FFFF);
        rd(0, 12'h304, v); chk("R11 misaligned write ignored", v, 32'h1234_5670);
        rd(0, 12'h240, v); chk("R11 unlisted offset", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(0, 12'h100, 32'h7FFF_FFF8);
        rd(0, 12'h100, v); chk("R7 masked merge", v, 32'h30FF_0000);
        wr(0, 12'h100, 32'h0);
        rd(0, 12'h100, v); chk("R7 masked clear", v, 0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(0, 12'h400, 32'h1);
        chk("R8 start on 0->1", {16'h0, last_start}, 32'h0010);
        @(negedge clk);
        chk("R8 start one cycle", {16'h0, start}, 0);
        wr(0, 12'h400, 32'h1);
        chk("R8 no start when already active", {16'h0, last_start}, 0);
        wr(0, 12'hFF0, 32'hFFBF);
        rd(0, 12'hFF0, v); chk("R3 enable write", v, 32'hFFBF);
        chk("R3 chan_en port", {16'h0, chan_en}, 32'hFFBF);
        wr(0, 12'h600, 32'h1);
        chk("R8 no start on disabled channel", {16'h0, last_start}, 0);
        wr(0, 12'hFF0, 32'hFFFF);
    endtask

    task automatic t_done();
        logic [31:0] v;
        done(4'd4, 1'b1);
        chk("R9 irq raised", {16'h0, irq}, 32'h0010);
        rd(0, 12'h400, v); chk("R9 status after done", v, 32'h16);
        rd(0, 12'hFE0, v); chk("R9 gstat", v, 32'h0010);
        wr(0, 12'h400, 32'h2);
        rd(0, 12'h400, v); chk("R5 end cleared", v, 32'h14);
        wr(0, 12'hFE0, 32'h0);
        chk("R3 gstat write ignored", {16'h0, irq}, 32'h0010);
        wr(0, 12'h400, 32'h4);
        chk("R6 irq dropped", {16'h0, irq}, 0);
        rd(0, 12'h400, v); chk("R6 int flag cleared", v, 32'h10);
        rd(0, 12'hFE0, v); chk("R6 gstat cleared", v, 0);
        done(4'd7, 1'b0);
        rd(0, 12'h700, v); chk("R9 done without int", v, 32'h12);
        chk("R9 no irq without int", {16'h0, irq}, 0);
    endtask

    task automatic t_chreset();
        logic [31:0] v;
        wr(0, 12'h320, 32'h0000_BEEF);
        wr(0, 12'h300, 32'h0000_0001);
        wr(0, 12'h300, 32'h8000_0000);
        rd(0, 12'h300, v); chk("R4 status zero", v, 0);
        rd(0, 12'h304, v); chk("R4 pointer zero", v, 0);
        rd(0, 12'h320, v); chk("R4 debug kept", v, 32'h0000_BEEF);
        wr(0, 12'h300, 32'h8000_0001);
        chk("R4 R8 reset then start", {16'h0, last_start}, 32'h0008);
        rd(0, 12'h300, v); chk("R4 merge after reset", v, 32'h1);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        done(4'd9, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h900; req_wdata = 32'h4;
        done_valid = 1'b1; done_chan = 4'd9; done_int = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; done_valid = 1'b0; done_int = 1'b0;
        chk("R10 irq kept", {16'h0, irq}, 32'h0200);
        rd(0, 12'h900, v); chk("R10 flag kept", v, 32'h16);
        rd(0, 12'hFE0, v); chk("R10 gstat kept", v, 32'h0200);
        wr(0, 12'h900, 32'h4);
        chk("R6 later clear", {16'h0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_mirror();
        t_unmapped();
        t_mask();
        t_start();
        t_done();
        t_chreset();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule